// File: doc/BRIEF.md
# Three-Bank Level-Sensitive Interrupt Controller

The block gathers 96 level-sensitive interrupt sources, arranged as three banks of 32, and presents two request outputs to a processor: a normal request (IRQ) and a fast request (FIQ). Each source carries a 6-bit priority and a class bit that routes it to one of the two outputs. Software reaches the controller through a simple 32-bit word-addressed register port. Writes commit on the clock edge. Reads are combinational and have no side effects.

Every bank holds a sampled copy of its inputs, a mask, and a set of software-forced request bits. A line is pending when its sampled input or its software bit is high. A line is eligible for its class when it is pending and unmasked. Each output channel has an arm flag. While the channel is armed and the global mask is off, the first cycle in which any line of that class is eligible raises the output and latches the winning line number as the vector. The output then stays high until software re-arms the channel through the control register. Reading a vector never clears a pending line, so a source keeps requesting until it drops its input or software clears its software bit.

Top module: `intc_lvl_ctrl`

## Requirements
- R1: After reset, word 0x00 reads 0x21, word 0x14 reads 1, every bank mask reads all ones, every line word reads 0, word 0x48 reads 0, and both outputs are low.
- R2: Bank word +0x00 (bank b at 0x80+0x20*b) reads the input bits sampled one clock earlier. A line whose input drops stays pending only if its software bit is set.
- R3: Bank word +0x04 loads the mask (1 = masked). A write to +0x08 clears the written mask bits and a write to +0x0C sets them. Both of these words read 0.
- R4: A write to bank word +0x10 ORs its value into the software bits, and that word reads them back. A write to +0x14 clears the written software bits and reads 0. Software bits count as pending exactly like inputs.
- R5: Bank word +0x18 reads pending AND NOT mask for lines of class 0 (IRQ). Word +0x1C reads the same for class 1 (FIQ).
- R6: The word at 0x100+4n configures line n (0..95). Bits [7:2] hold its priority and bit 0 its class (1 = FIQ). All other bits are dropped and read back as 0.
- R7: When a channel is armed, the global mask is off and a line of its class is eligible, the output rises at the next clock edge and the vector (IRQ at 0x40, FIQ at 0x44) latches the winner. The output stays high until it is re-armed.
- R8: The winner is the eligible line with the numerically smallest priority. Among equal priorities the highest line number wins.
- R9: Writing word 0x48 with bit 0 (IRQ) or bit 1 (FIQ) set lowers that output at the next edge and re-arms it, so a still-eligible line fires again one cycle later. Reading a vector clears nothing.
- R10: Bit 2 of word 0x48 is a global mask that stops either output from rising while it is set. It reads back at bit 2.
- R11: Word 0x10 bit 0 stores an autoidle bit that reads back. Word 0x50 stores 2 idle bits. Word 0x4C reads 0. Writing 0x10 with bit 1 set returns every register and both channels to their reset state.
- R12: Writes to words 0x00, 0x14, 0x40, 0x44, bank +0x00, +0x18 and +0x1C have no effect. Bank index 3, lines beyond 95 and undefined words read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NB*32 | Level interrupt sources, line n on bit n |
| req_i | input | 1 | Register access valid |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | AW | Byte address; bits [1:0] are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Several properties are checked on every cycle. A raised output holds until it is re-armed or soft-reset. An armed channel with an eligible line fires and latches the winner. The global mask keeps a low output low. The mask-clear and software set/clear words act only on their written bits. The resolver's winner is always a requesting line. Other behaviours need the bench's scenarios to show them: the priority order between competing lines, including ties across banks; the merge of software bits with levels when inputs drop; the read-only and out-of-range words; and the full return to reset state after a soft reset. These are judged against a behavioural model that the bench steps every clock.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned BANK_W = 32;

  typedef enum logic [2:0] {
    BR_RAW  = 3'd0,
    BR_MASK = 3'd1,
    BR_MCLR = 3'd2,
    BR_MSET = 3'd3,
    BR_SSET = 3'd4,
    BR_SCLR = 3'd5,
    BR_PIRQ = 3'd6,
    BR_PFIQ = 3'd7
  } bank_reg_e;

  // global word indices (byte address >> 2)
  localparam logic [4:0] G_REV    = 5'd0;
  localparam logic [4:0] G_SYSCFG = 5'd4;
  localparam logic [4:0] G_STAT   = 5'd5;
  localparam logic [4:0] G_VIRQ   = 5'd16;
  localparam logic [4:0] G_VFIQ   = 5'd17;
  localparam logic [4:0] G_CTRL   = 5'd18;
  localparam logic [4:0] G_PROT   = 5'd19;
  localparam logic [4:0] G_IDLE   = 5'd20;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [BANK_W-1:0] src_i,
  input  logic [BANK_W-1:0] steer_i,
  input  logic              we_i,
  input  logic              sel_i,
  input  bank_reg_e         reg_i,
  input  logic [31:0]       wdata_i,
  output logic [BANK_W-1:0] pend_o,
  output logic [BANK_W-1:0] mask_o,
  output logic [31:0]       rdata_o
);
  logic [BANK_W-1:0] inp_q, mask_q, swi_q;
  logic              wr;

  assign wr = we_i & sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inp_q  <= '0;
      mask_q <= '1;
      swi_q  <= '0;
    end else begin
      inp_q <= src_i;
      if (clr_i) begin
        mask_q <= '1;
        swi_q  <= '0;
      end else if (wr) begin
        case (reg_i)
          BR_MASK: mask_q <= wdata_i;
          BR_MCLR: mask_q <= mask_q & ~wdata_i;
          BR_MSET: mask_q <= mask_q | wdata_i;
          BR_SSET: swi_q  <= swi_q | wdata_i;
          BR_SCLR: swi_q  <= swi_q & ~wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign pend_o = inp_q | swi_q;
  assign mask_o = mask_q;

  always_comb begin
    case (reg_i)
      BR_RAW:  rdata_o = inp_q;
      BR_MASK: rdata_o = mask_q;
      BR_SSET: rdata_o = swi_q;
      BR_PIRQ: rdata_o = pend_o & ~mask_q & ~steer_i;
      BR_PFIQ: rdata_o = pend_o & ~mask_q & steer_i;
      default: rdata_o = '0;
    endcase
  end

  p_mclr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && !clr_i && reg_i == BR_MCLR |=> (mask_q & $past(wdata_i)) == '0);
  p_sset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && !clr_i && reg_i == BR_SSET |=> (swi_q & $past(wdata_i)) == $past(wdata_i));
  p_sclr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && !clr_i && reg_i == BR_SCLR |=> (swi_q & $past(wdata_i)) == '0);
endmodule

// File: rtl/intc_line_cfg.sv
module intc_line_cfg #(
  parameter int unsigned NL = 96,
  parameter int unsigned PW = 6,
  parameter int unsigned IW = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [IW-1:0]    line_i,
  input  logic [PW-1:0]    prio_w_i,
  input  logic             steer_w_i,
  output logic [NL*PW-1:0] prio_o,
  output logic [NL-1:0]    steer_o,
  output logic [31:0]      rdata_o
);
  logic [PW-1:0] prio_q [NL];
  logic [NL-1:0] steer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NL; i++) prio_q[i] <= '0;
      steer_q <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < NL; i++) prio_q[i] <= '0;
      steer_q <= '0;
    end else if (we_i) begin
      prio_q[line_i]  <= prio_w_i;
      steer_q[line_i] <= steer_w_i;
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_flat
    assign prio_o[g*PW +: PW] = prio_q[g];
  end
  assign steer_o = steer_q;

  assign rdata_o = {{(32-PW-2){1'b0}}, prio_q[line_i], 1'b0, steer_q[line_i]};
endmodule

// File: rtl/intc_prio_tree.sv
module intc_prio_tree #(
  parameter int unsigned NL = 96,
  parameter int unsigned PW = 6,
  parameter int unsigned IW = 7
) (
  input  logic [NL-1:0]    req_i,
  input  logic [NL*PW-1:0] prio_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  localparam int unsigned LV = $clog2(NL);
  localparam int unsigned NP = 1 << LV;

  // heap layout: node k has children 2k (lower lines) and 2k+1 (higher lines)
  logic [2*NP-1:1] v;
  logic [PW-1:0]   p [1:2*NP-1];
  logic [IW-1:0]   x [1:2*NP-1];

  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < NL) begin : g_real
      assign v[NP+i] = req_i[i];
      assign p[NP+i] = prio_i[i*PW +: PW];
      assign x[NP+i] = IW'(i);
    end else begin : g_pad
      assign v[NP+i] = 1'b0;
      assign p[NP+i] = '0;
      assign x[NP+i] = '0;
    end
  end

  for (genvar k = 1; k < NP; k++) begin : g_node
    logic take_hi;
    // ties go to the higher line number
    assign take_hi = v[2*k+1] && (!v[2*k] || (p[2*k+1] <= p[2*k]));
    assign v[k] = v[2*k] | v[2*k+1];
    assign p[k] = take_hi ? p[2*k+1] : p[2*k];
    assign x[k] = take_hi ? x[2*k+1] : x[2*k];
  end

  assign any_o = v[1];
  assign idx_o = x[1];

  always_comb begin
    if (any_o) p_win_req_r8: assert (req_i[idx_o]);
  end
endmodule

// File: rtl/intc_out_chan.sv
module intc_out_chan #(
  parameter int unsigned NL = 96,
  parameter int unsigned PW = 6,
  parameter int unsigned IW = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             rearm_i,
  input  logic             gmask_i,
  input  logic [NL-1:0]    req_i,
  input  logic [NL*PW-1:0] prio_i,
  output logic             out_o,
  output logic [IW-1:0]    vec_o
);
  logic          arm_q, out_q, any;
  logic [IW-1:0] vec_q, win;

  intc_prio_tree #(.NL(NL), .PW(PW), .IW(IW)) u_tree (
    .req_i (req_i),
    .prio_i(prio_i),
    .any_o (any),
    .idx_o (win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b1;
      out_q <= 1'b0;
      vec_q <= '0;
    end else if (clr_i) begin
      arm_q <= 1'b1;
      out_q <= 1'b0;
      vec_q <= '0;
    end else if (rearm_i) begin
      arm_q <= 1'b1;
      out_q <= 1'b0;
    end else if (arm_q && any && !gmask_i) begin
      arm_q <= 1'b0;
      out_q <= 1'b1;
      vec_q <= win;
    end
  end

  assign out_o = out_q;
  assign vec_o = vec_q;

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q && !rearm_i && !clr_i |=> out_q);
  p_fire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q && any && !gmask_i && !rearm_i && !clr_i |=> out_q && vec_q == $past(win));
  p_rearm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> !out_q);
  p_gmask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gmask_i && !out_q |=> !out_q);
  p_vec_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, vec_q} < (IW+1)'(NL));
endmodule

// File: rtl/intc_lvl_ctrl.sv
module intc_lvl_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned NB  = 3,
  parameter int unsigned PW  = 6,
  parameter int unsigned AW  = 12,
  parameter logic [7:0]  REV = 8'h21
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NB*BANK_W-1:0] src_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic                 irq_o,
  output logic                 fiq_o
);
  localparam int unsigned NL = NB * BANK_W;
  localparam int unsigned IW = $clog2(NL);
  localparam logic [AW-3:0] LBASE = (AW-2)'(64);
  localparam logic [AW-3:0] NLW   = (AW-2)'(NL);

  // decode
  logic          is_glob, is_bank, bank_ok, line_ok, wr_g, soft_rst, ctrl_wr;
  logic [4:0]    g;
  logic [1:0]    bsel;
  bank_reg_e     breg;
  logic [AW-3:0] widx, lrel;
  logic          unused_addr;

  assign unused_addr = ^addr_i[1:0];
  assign widx     = addr_i[AW-1:2];
  assign lrel     = widx - LBASE;
  assign is_glob  = req_i && (addr_i[AW-1:7] == '0);
  assign is_bank  = req_i && (addr_i[AW-1:7] == (AW-7)'(1));
  assign g        = addr_i[6:2];
  assign bsel     = addr_i[6:5];
  assign breg     = bank_reg_e'(addr_i[4:2]);
  assign bank_ok  = int'(bsel) < NB;
  assign line_ok  = req_i && (widx >= LBASE) && (lrel < NLW);
  assign wr_g     = is_glob && we_i;
  assign soft_rst = wr_g && (g == G_SYSCFG) && wdata_i[1];
  assign ctrl_wr  = wr_g && (g == G_CTRL);

  // global state
  logic       autoidle_q, gmask_q;
  logic [1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      autoidle_q <= 1'b0;
      gmask_q    <= 1'b0;
      idle_q     <= '0;
    end else if (soft_rst) begin
      autoidle_q <= 1'b0;
      gmask_q    <= 1'b0;
      idle_q     <= '0;
    end else if (wr_g) begin
      case (g)
        G_SYSCFG: autoidle_q <= wdata_i[0];
        G_CTRL:   gmask_q    <= wdata_i[2];
        G_IDLE:   idle_q     <= wdata_i[1:0];
        default: ;
      endcase
    end
  end

  // line configuration
  logic [NL*PW-1:0] prio_all;
  logic [NL-1:0]    steer_all;
  logic [31:0]      cfg_rd;

  intc_line_cfg #(.NL(NL), .PW(PW), .IW(IW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (soft_rst),
    .we_i     (line_ok && we_i),
    .line_i   (lrel[IW-1:0]),
    .prio_w_i (wdata_i[PW+1:2]),
    .steer_w_i(wdata_i[0]),
    .prio_o   (prio_all),
    .steer_o  (steer_all),
    .rdata_o  (cfg_rd)
  );

  // banks
  logic [NL-1:0] pend_all, mask_all;
  logic [31:0]   brd [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    intc_bank u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (soft_rst),
      .src_i  (src_i[b*BANK_W +: BANK_W]),
      .steer_i(steer_all[b*BANK_W +: BANK_W]),
      .we_i   (we_i),
      .sel_i  (is_bank && (bsel == 2'(b))),
      .reg_i  (breg),
      .wdata_i(wdata_i),
      .pend_o (pend_all[b*BANK_W +: BANK_W]),
      .mask_o (mask_all[b*BANK_W +: BANK_W]),
      .rdata_o(brd[b])
    );
  end

  // output channels: 0 = IRQ class, 1 = FIQ class
  logic [NL-1:0] elig [2];
  logic [1:0]    outs;
  logic [IW-1:0] vec [2];

  assign elig[0] = pend_all & ~mask_all & ~steer_all;
  assign elig[1] = pend_all & ~mask_all & steer_all;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    intc_out_chan #(.NL(NL), .PW(PW), .IW(IW)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (soft_rst),
      .rearm_i(ctrl_wr && wdata_i[c]),
      .gmask_i(gmask_q),
      .req_i  (elig[c]),
      .prio_i (prio_all),
      .out_o  (outs[c]),
      .vec_o  (vec[c])
    );
  end

  assign irq_o = outs[0];
  assign fiq_o = outs[1];

  // read mux
  always_comb begin
    rdata_o = '0;
    if (is_glob) begin
      case (g)
        G_REV:    rdata_o = 32'(REV);
        G_SYSCFG: rdata_o = {31'b0, autoidle_q};
        G_STAT:   rdata_o = 32'd1;
        G_VIRQ:   rdata_o = 32'(vec[0]);
        G_VFIQ:   rdata_o = 32'(vec[1]);
        G_CTRL:   rdata_o = {29'b0, gmask_q, 2'b0};
        G_IDLE:   rdata_o = {30'b0, idle_q};
        default:  rdata_o = '0;
      endcase
    end else if (is_bank && bank_ok) begin
      rdata_o = brd[bsel];
    end else if (line_ok) begin
      rdata_o = cfg_rd;
    end
  end

  p_soft_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> !gmask_q && !autoidle_q && idle_q == 2'b0 && !irq_o && !fiq_o);
  p_gmask_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !soft_rst |=> gmask_q == $past(wdata_i[2]));
endmodule

// File: tb/tb_intc_lvl_ctrl.sv
module tb_intc_lvl_ctrl;
  localparam int CLK_P = 10;
  localparam int NB = 3;
  localparam int NL = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] src = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, fiq;

  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  intc_lvl_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  // behavioural reference model
  logic [31:0] m_inp [NB], m_mask [NB], m_swi [NB];
  int          m_prio [NL];
  bit          m_steer [NL];
  bit          m_arm [2], m_out [2];
  int          m_vec [2];
  bit          m_gm, m_ai;
  int          m_idle;

  function automatic void m_reset(bit keep_inp);
    for (int b = 0; b < NB; b++) begin
      if (!keep_inp) m_inp[b] = 0;
      m_mask[b] = 32'hFFFF_FFFF;
      m_swi[b] = 0;
    end
    for (int i = 0; i < NL; i++) begin m_prio[i] = 0; m_steer[i] = 0; end
    for (int c = 0; c < 2; c++) begin m_arm[c] = 1; m_out[c] = 0; m_vec[c] = 0; end
    m_gm = 0; m_ai = 0; m_idle = 0;
  endfunction

  function automatic bit m_elig(int i, int c);
    int b = i / 32;
    int k = i % 32;
    bit pend = m_inp[b][k] | m_swi[b][k];
    return pend && !m_mask[b][k] && (int'(m_steer[i]) == c);
  endfunction

  function automatic int m_pick(int c);
    int best = 1000;
    int who = -1;
    for (int i = 0; i < NL; i++)
      if (m_elig(i, c) && m_prio[i] <= best) begin best = m_prio[i]; who = i; end
    return who;
  endfunction

  function automatic logic [31:0] m_view(int b, int c);
    logic [31:0] r = 0;
    for (int k = 0; k < 32; k++) r[k] = m_elig(b*32 + k, c);
    return r;
  endfunction

  function automatic logic [31:0] m_read(int a);
    int b, r, ln;
    case (a)
      'h00: return 32'h21;
      'h10: return {31'b0, m_ai};
      'h14: return 1;
      'h40: return m_vec[0];
      'h44: return m_vec[1];
      'h48: return {29'b0, m_gm, 2'b0};
      'h50: return m_idle;
      default: ;
    endcase
    if (a >= 'h80 && a < 'h100) begin
      b = (a - 'h80) / 32;
      r = (a % 32) / 4;
      if (b >= NB) return 0;
      case (r)
        0: return m_inp[b];
        1: return m_mask[b];
        4: return m_swi[b];
        6: return m_view(b, 0);
        7: return m_view(b, 1);
        default: return 0;
      endcase
    end
    if (a >= 'h100) begin
      ln = (a - 'h100) / 4;
      if (ln < NL) return (m_prio[ln] << 2) | int'(m_steer[ln]);
    end
    return 0;
  endfunction

  function automatic void m_step();
    int w [2];
    int a = int'(addr);
    int b, r, ln;
    for (int c = 0; c < 2; c++) w[c] = m_pick(c);
    if (req && we && a == 'h10 && wdata[1]) begin
      m_reset(1'b1);
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (req && we && a == 'h48 && wdata[c]) begin
          m_out[c] = 0; m_arm[c] = 1;
        end else if (m_arm[c] && w[c] >= 0 && !m_gm) begin
          m_out[c] = 1; m_arm[c] = 0; m_vec[c] = w[c];
        end
      end
      if (req && we) begin
        if (a == 'h10) m_ai = wdata[0];
        if (a == 'h48) m_gm = wdata[2];
        if (a == 'h50) m_idle = int'(wdata[1:0]);
        if (a >= 'h80 && a < 'h100) begin
          b = (a - 'h80) / 32;
          r = (a % 32) / 4;
          if (b < NB) case (r)
            1: m_mask[b] = wdata;
            2: m_mask[b] = m_mask[b] & ~wdata;
            3: m_mask[b] = m_mask[b] | wdata;
            4: m_swi[b] = m_swi[b] | wdata;
            5: m_swi[b] = m_swi[b] & ~wdata;
            default: ;
          endcase
        end
        if (a >= 'h100) begin
          ln = (a - 'h100) / 4;
          if (ln < NL) begin m_prio[ln] = int'(wdata[7:2]); m_steer[ln] = wdata[0]; end
        end
      end
    end
    for (int k = 0; k < NB; k++) m_inp[k] = src[k*32 +: 32];
  endfunction

  initial m_reset(1'b0);
  always @(posedge clk) if (!rst_n) m_reset(1'b0); else m_step();

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison of both outputs against the model (R7, R9, R10)
  always @(negedge clk) if (rst_n) begin
    chk(irq == m_out[0], "R7 irq_o vs model", {31'b0, irq}, {31'b0, m_out[0]});
    chk(fiq == m_out[1], "R7 fiq_o vs model", {31'b0, fiq}, {31'b0, m_out[1]});
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; wdata = '0;
  endtask

  task automatic rdx(input logic [11:0] a, input logic [31:0] e, input string tag);
    req = 1; we = 0; addr = a;
    #1;
    chk(rdata === e, tag, rdata, e);
    chk(rdata === m_read(int'(a)), tag, rdata, m_read(int'(a)));
    @(negedge clk);
    req = 0;
  endtask

  task automatic rdm(input logic [11:0] a, input string tag);
    req = 1; we = 0; addr = a;
    #1;
    chk(rdata === m_read(int'(a)), tag, rdata, m_read(int'(a)));
    @(negedge clk);
    req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    idle(1);

    // R1 reset state
    rdx(12'h000, 32'h21, "R1 revision");
    rdx(12'h014, 32'h1, "R1 status");
    rdx(12'h084, 32'hFFFF_FFFF, "R1 bank0 mask");
    rdx(12'h0C4, 32'hFFFF_FFFF, "R1 bank2 mask");
    rdx(12'h048, 32'h0, "R1 control");
    rdx(12'h114, 32'h0, "R1 line5 cfg");
    chk(!irq && !fiq, "R1 outputs low", {30'b0, fiq, irq}, 0);

    // R2 raw input, R5 masked view
    src[5] = 1'b1;
    idle(2);
    rdx(12'h080, 32'h20, "R2 raw input");
    rdx(12'h098, 32'h0, "R5 masked irq view");

    // R3 mask clear, R7 fire and vector
    wr(12'h088, 32'h20);
    rdx(12'h084, ~32'h20, "R3 mask clear");
    rdx(12'h088, 32'h0, "R3 mask clear reads 0");
    idle(2);
    chk(irq == 1'b1, "R7 irq raised", {31'b0, irq}, 1);
    rdx(12'h040, 32'd5, "R7 irq vector");
    rdx(12'h098, 32'h20, "R9 pending kept after vector read");

    // R3 mask set / write, output holds
    wr(12'h08C, 32'h20);
    rdx(12'h084, 32'hFFFF_FFFF, "R3 mask set");
    rdx(12'h08C, 32'h0, "R3 mask set reads 0");
    chk(irq == 1'b1, "R7 hold while masked", {31'b0, irq}, 1);
    wr(12'h084, ~32'h20);
    rdx(12'h084, ~32'h20, "R3 mask write");

    // R8 lowest priority value wins
    wr(12'h100 + 12'd20, 32'd10 << 2);
    wr(12'h100 + 12'd160, 32'd3 << 2);
    wr(12'h0A4, ~32'h100);
    src[40] = 1'b1;
    idle(2);
    wr(12'h048, 32'h1);
    chk(irq == 1'b0, "R9 rearm drops irq", {31'b0, irq}, 0);
    idle(2);
    rdx(12'h040, 32'd40, "R8 lowest value wins");

    // R8 tie goes to highest line
    wr(12'h100 + 12'd280, 32'd3 << 2);
    wr(12'h0C4, ~32'h40);
    src[70] = 1'b1;
    idle(2);
    wr(12'h048, 32'h1);
    idle(2);
    rdx(12'h040, 32'd70, "R8 tie highest line");

    // R6 config fields, R7 fiq, R5 views
    wr(12'h218, 32'hFFFF_FF0F);
    rdx(12'h218, 32'h0D, "R6 cfg fields");
    wr(12'h048, 32'h3);
    idle(2);
    chk(fiq == 1'b1, "R7 fiq raised", {31'b0, fiq}, 1);
    rdx(12'h044, 32'd70, "R7 fiq vector");
    rdx(12'h040, 32'd40, "R8 irq vector after steer");
    rdx(12'h0D8, 32'h0, "R5 bank2 irq view");
    rdx(12'h0DC, 32'h40, "R5 bank2 fiq view");
    rdx(12'h0B8, 32'h100, "R5 bank1 irq view");

    // R10 global mask
    wr(12'h048, 32'h5);
    idle(4);
    chk(irq == 1'b0, "R10 global mask blocks irq", {31'b0, irq}, 0);
    rdx(12'h048, 32'h4, "R10 mask readback");
    wr(12'h048, 32'h0);
    idle(2);
    chk(irq == 1'b1, "R10 irq after unmask", {31'b0, irq}, 1);

    // R2 level drop, R4 software bits
    src = '0;
    idle(2);
    rdx(12'h080, 32'h0, "R2 raw drop");
    rdx(12'h098, 32'h0, "R2 pending gone on drop");
    wr(12'h090, 32'h220);
    rdx(12'h090, 32'h220, "R4 software set readback");
    rdx(12'h098, 32'h20, "R4 software merged into pending");
    src[5] = 1'b1;
    idle(2);
    src[5] = 1'b0;
    idle(2);
    rdx(12'h098, 32'h20, "R2 drop keeps software bit");
    wr(12'h094, 32'h200);
    rdx(12'h094, 32'h0, "R4 software clear reads 0");
    rdx(12'h090, 32'h20, "R4 software clear");
    wr(12'h094, 32'h20);
    rdx(12'h098, 32'h0, "R4 pending after full clear");

    // R12 read-only and out-of-range
    wr(12'h000, 32'hFF);
    rdx(12'h000, 32'h21, "R12 revision read-only");
    wr(12'h014, 32'h0);
    rdx(12'h014, 32'h1, "R12 status read-only");
    wr(12'h040, 32'h7F);
    rdm(12'h040, "R12 vector read-only");
    wr(12'h080, 32'hFFFF_FFFF);
    rdx(12'h080, 32'h0, "R12 raw read-only");
    wr(12'h098, 32'hFFFF_FFFF);
    rdx(12'h098, 32'h0, "R12 view read-only");
    wr(12'h0E4, 32'h0);
    rdx(12'h0E4, 32'h0, "R12 bank3 reads 0");
    rdx(12'h084, ~32'h20, "R12 bank3 write ignored b0");
    rdx(12'h0C4, ~32'h40, "R12 bank3 write ignored b2");
    rdx(12'h020, 32'h0, "R12 undefined word");
    wr(12'h280, 32'hFF);
    rdx(12'h280, 32'h0, "R12 line beyond range");

    // R11 misc and soft reset
    wr(12'h04C, 32'h1);
    rdx(12'h04C, 32'h0, "R11 protection reads 0");
    wr(12'h050, 32'h3);
    rdx(12'h050, 32'h3, "R11 idle bits");
    wr(12'h010, 32'h1);
    rdx(12'h010, 32'h1, "R11 autoidle");
    wr(12'h048, 32'h4);
    wr(12'h010, 32'h2);
    rdx(12'h010, 32'h0, "R11 soft reset autoidle");
    rdx(12'h050, 32'h0, "R11 soft reset idle");
    rdx(12'h048, 32'h0, "R11 soft reset control");
    rdx(12'h084, 32'hFFFF_FFFF, "R11 soft reset mask");
    rdx(12'h218, 32'h0, "R11 soft reset cfg");
    chk(!irq && !fiq, "R11 soft reset outputs", {30'b0, fiq, irq}, 0);

    idle(2);
    finish_run();
  end
endmodule